// File: doc/BRIEF.md
# Asynchronous Static Memory Strobe Sequencer

This block runs single accesses to one asynchronous external memory device (SRAM, NOR flash, peripheral register file). A host presents a request with direction, address, write data and byte enables; the block drives an active-low chip select, a read strobe or a write strobe, the address and the byte enables. For reads it captures the returned data, and it reports completion with a one-clock done pulse.

Four 32-bit configuration words shape every access. The setup and pulse words give the setup and active lengths of the chip select and of the data strobe, with separate fields for reads and for writes. The cycle word gives the total access length. All three use compressed encodings in which a high bit carries a large multiplier. The mode word selects which signal controls the access, how the external wait input acts, the data bus width, and the turnaround delay that must follow a read before the bus may be driven again.

The configuration words are expected to stay stable while an access is in flight.

Top module: `smc_timing_engine`

## Requirements
- R1: Each signal takes its 8-bit setup field from `cfg_setup` and its 8-bit pulse field from `cfg_pulse`, at these bit positions:
  - write strobe at [7:0]
  - chip select for writes at [15:8]
  - read strobe at [23:16]
  - chip select for reads at [31:24]

  A setup field f decodes to 128·f[5] + f[4:0] clocks.
- R2: A pulse field f decodes to 256·f[6] + f[5:0] clocks. A decoded pulse of 0 acts as 1 clock.
- R3: The access length comes from `cfg_cycle`: bits [8:0] for writes and bits [24:16] for reads. A field c decodes to 256·c[8:7] + c[6:0] clocks. If that is shorter than setup+pulse of the chip select or of the data strobe, the access is stretched to the larger of the two.
- R4: The access clocks are numbered n = 0 … L−1, where clock 0 is the clock after acceptance. A signal is low exactly while setup ≤ n < setup+pulse.
  - Only the strobe for the access direction ever goes low.
  - Outside an access, `mem_cs_n`, `mem_rd_n` and `mem_we_n` are all high.
- R5: A read captures `mem_dq_i` on the edge where the controlling signal deasserts. `cfg_mode[0]`=1 selects the read strobe as the controlling signal; `cfg_mode[0]`=0 selects the chip select.
- R6: `done_o` is high for exactly one clock, the clock after the last access clock. `rdata_o` keeps its value from that point until the next read capture, and writes leave it unchanged.
- R7: `mem_dq_oe` is high with `mem_dq_o` = the write data for every clock of a write access, and low at all other times.
- R8: With `cfg_mode[5:4]`=2, every access clock on which `mem_wait_n` is low repeats the current phase position, so the bus outputs hold.
- R9: With `cfg_mode[5:4]`=3, the controlling pulse cannot leave its last clock while `mem_wait_n` is low. The controlling signal is selected by `cfg_mode[1]` for writes and `cfg_mode[0]` for reads (1 = strobe, 0 = chip select). With `cfg_mode[5:4]` equal to 0 or 1, `mem_wait_n` has no effect.
- R10: After a read, `ready_o` stays low for `cfg_mode[19:16]`+1 clocks starting with the done clock. With `cfg_mode[20]`=1, this hold-off is waived when `we_i`=0. Writes add no hold-off.
- R11: `cfg_mode[13:12]` selects the bus width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits.
  - `mem_be_n` is the inverse of `be_i` masked to the active bytes.
  - Read data is zeroed above the bus width.
- R12: A request is taken only when `req_i` and `ready_o` are both high. `ready_o` is low during an access. Address, data and byte enables are latched at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | 32 | Setup lengths, four encoded fields |
| cfg_pulse | input | 32 | Pulse lengths, four encoded fields |
| cfg_cycle | input | 32 | Write and read access lengths |
| cfg_mode | input | 32 | Control, wait mode, width, turnaround |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| be_i | input | DW/8 | Byte enables, active high |
| ready_o | output | 1 | Request may be accepted |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DW | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | External address |
| mem_be_n | output | DW/8 | Byte enables, active low |
| mem_dq_o | output | DW | Data driven to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | DW | Data returned by memory |
| mem_wait_n | input | 1 | External wait, active low |

## Verification
A corrupted phase counter or mis-decoded field shows on the strobe pins in the same clock, because they are plain compares against the counter. A wrong capture point shows up only at the done clock, as a wrong `rdata_o`. To make that visible, the bench changes `mem_dq_i` on every access clock, so each capture point returns a distinct value. A wrong turnaround count is visible only through `ready_o` during the clocks after a read.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int LEN_W = 10;
    localparam int FLT_W = 5;

    typedef enum logic [1:0] {
        WAIT_OFF    = 2'd0,
        WAIT_RSVD   = 2'd1,
        WAIT_FREEZE = 2'd2,
        WAIT_READY  = 2'd3
    } wait_mode_e;

    // setup field: bit 5 weighs 128, bits 4..0 are linear
    function automatic logic [LEN_W-1:0] setup_clocks(input logic [7:0] f);
        return LEN_W'({f[5], 7'd0}) + LEN_W'(f[4:0]);
    endfunction

    // pulse field: bit 6 weighs 256, bits 5..0 are linear, zero counts as one
    function automatic logic [LEN_W-1:0] pulse_clocks(input logic [7:0] f);
        logic [LEN_W-1:0] v;
        v = LEN_W'({f[6], 8'd0}) + LEN_W'(f[5:0]);
        return (v == '0) ? LEN_W'(1) : v;
    endfunction

    // cycle field: bits 8..7 weigh 256, bits 6..0 are linear
    function automatic logic [LEN_W-1:0] cycle_clocks(input logic [8:0] f);
        return LEN_W'({f[8:7], 8'd0}) + LEN_W'(f[6:0]);
    endfunction

endpackage

// File: rtl/smc_len_decode.sv
module smc_len_decode
    import smc_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  logic [31:0]      setup_w,
    input  logic [31:0]      pulse_w,
    input  logic [31:0]      cycle_w,
    input  logic [31:0]      mode_w,
    input  logic             is_wr,
    output logic [LEN_W-1:0] cs_beg,
    output logic [LEN_W-1:0] cs_end,
    output logic [LEN_W-1:0] st_beg,
    output logic [LEN_W-1:0] st_end,
    output logic [LEN_W-1:0] total,
    output logic [LEN_W-1:0] ctrl_end,
    output wait_mode_e       wmode,
    output logic [FLT_W-1:0] float_len,
    output logic             float_opt,
    output logic [BE_W-1:0]  byte_mask
);

    // index 0: data strobe, index 1: chip select
    logic [1:0][LEN_W-1:0] beg_v;
    logic [1:0][LEN_W-1:0] end_v;
    logic [4:0]            base;
    logic [8:0]            cyc_f;
    logic                  ctrl_sel;
    logic                  unused_bits;

    assign base = is_wr ? 5'd0 : 5'd16;

    for (genvar g = 0; g < 2; g++) begin : g_sig
        logic [4:0]       off;
        logic [LEN_W-1:0] s_len;
        logic [LEN_W-1:0] p_len;
        assign off      = base + 5'(8 * g);
        assign s_len    = setup_clocks(setup_w[off +: 8]);
        assign p_len    = pulse_clocks(pulse_w[off +: 8]);
        assign beg_v[g] = s_len;
        assign end_v[g] = s_len + p_len;
    end

    assign st_beg = beg_v[0];
    assign st_end = end_v[0];
    assign cs_beg = beg_v[1];
    assign cs_end = end_v[1];

    assign cyc_f    = is_wr ? cycle_w[8:0] : cycle_w[24:16];
    assign ctrl_sel = is_wr ? mode_w[1] : mode_w[0];

    always_comb begin
        total = cycle_clocks(cyc_f);
        if (end_v[0] > total) total = end_v[0];
        if (end_v[1] > total) total = end_v[1];
    end

    assign ctrl_end  = ctrl_sel ? end_v[0] : end_v[1];
    assign wmode     = wait_mode_e'(mode_w[5:4]);
    assign float_len = {1'b0, mode_w[19:16]} + FLT_W'(1);
    assign float_opt = mode_w[20];

    for (genvar b = 0; b < BE_W; b++) begin : g_bmask
        assign byte_mask[b] = (mode_w[13:12] == 2'd0) ? (b == 0) :
                              (mode_w[13:12] == 2'd1) ? (b < 2)  : 1'b1;
    end

    assign unused_bits = ^{cycle_w[15:9], cycle_w[31:25], mode_w[31:21],
                           mode_w[15:14], mode_w[11:6], mode_w[3:2]};

endmodule

// File: rtl/smc_phase_core.sv
module smc_phase_core
    import smc_pkg::*;
#(
    parameter int AW   = 24,
    parameter int DW   = 32,
    parameter int BE_W = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [BE_W-1:0]  be_i,
    output logic             ready_o,
    output logic             done_o,
    output logic [DW-1:0]    rdata_o,
    output logic             cur_we_o,
    input  logic [LEN_W-1:0] cs_beg,
    input  logic [LEN_W-1:0] cs_end,
    input  logic [LEN_W-1:0] st_beg,
    input  logic [LEN_W-1:0] st_end,
    input  logic [LEN_W-1:0] total,
    input  logic [LEN_W-1:0] ctrl_end,
    input  wait_mode_e       wmode,
    input  logic [FLT_W-1:0] float_len,
    input  logic             float_opt,
    input  logic [BE_W-1:0]  byte_mask,
    output logic             mem_cs_n,
    output logic             mem_rd_n,
    output logic             mem_we_n,
    output logic [AW-1:0]    mem_addr,
    output logic [BE_W-1:0]  mem_be_n,
    output logic [DW-1:0]    mem_dq_o,
    output logic             mem_dq_oe,
    input  logic [DW-1:0]    mem_dq_i,
    input  logic             mem_wait_n
);

    typedef struct packed {
        logic             busy;
        logic             we;
        logic [LEN_W-1:0] cnt;
        logic [FLT_W-1:0] flt;
        logic             done;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [BE_W-1:0]  be;
        logic [DW-1:0]    rdata;
    } st_t;

    st_t         st_d, st_q;
    logic [DW-1:0] dmask;
    logic        hold_frz, hold_rdy, advance, cs_on, st_on;

    for (genvar b = 0; b < BE_W; b++) begin : g_dmask
        assign dmask[8*b +: 8] = {8{byte_mask[b]}};
    end

    assign ready_o  = !st_q.busy && ((st_q.flt == '0) || (float_opt && !we_i));
    assign hold_frz = (wmode == WAIT_FREEZE) && !mem_wait_n;
    assign hold_rdy = (wmode == WAIT_READY) && !mem_wait_n &&
                      (st_q.cnt == ctrl_end - LEN_W'(1));
    assign advance  = !(hold_frz || hold_rdy);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (st_q.flt != '0) st_d.flt = st_q.flt - FLT_W'(1);
            if (req_i && ready_o) begin
                st_d.busy  = 1'b1;
                st_d.we    = we_i;
                st_d.cnt   = '0;
                st_d.flt   = '0;
                st_d.addr  = addr_i;
                st_d.wdata = wdata_i;
                st_d.be    = be_i;
            end
        end else if (advance) begin
            if (!st_q.we && (st_q.cnt == ctrl_end - LEN_W'(1)))
                st_d.rdata = mem_dq_i & dmask;
            if (st_q.cnt == total - LEN_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
                st_d.flt  = st_q.we ? '0 : float_len;
            end else begin
                st_d.cnt = st_q.cnt + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cs_on     = st_q.busy && (st_q.cnt >= cs_beg) && (st_q.cnt < cs_end);
    assign st_on     = st_q.busy && (st_q.cnt >= st_beg) && (st_q.cnt < st_end);
    assign mem_cs_n  = !cs_on;
    assign mem_rd_n  = !(st_on && !st_q.we);
    assign mem_we_n  = !(st_on && st_q.we);
    assign mem_dq_oe = st_q.busy && st_q.we;
    assign mem_dq_o  = st_q.wdata;
    assign mem_addr  = st_q.addr;
    assign mem_be_n  = st_q.busy ? ~(st_q.be & byte_mask) : '1;
    assign done_o    = st_q.done;
    assign rdata_o   = st_q.rdata;
    assign cur_we_o  = st_q.we;

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_we_n)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> (mem_cs_n && mem_rd_n && mem_we_n && !mem_dq_oe)); // R4
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_rd_n); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && hold_frz) |=> (st_q.busy && $stable({mem_cs_n, mem_rd_n, mem_we_n}))); // R8
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && hold_rdy) |=> (st_q.busy && $stable({mem_cs_n, mem_rd_n, mem_we_n}))); // R9
    AST_FLOAT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && st_q.flt != '0 && we_i) |-> !ready_o); // R10

endmodule

// File: rtl/smc_timing_engine.sv
module smc_timing_engine
    import smc_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         cfg_setup,
    input  logic [31:0]         cfg_pulse,
    input  logic [31:0]         cfg_cycle,
    input  logic [31:0]         cfg_mode,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic [DW/8-1:0]     be_i,
    output logic                ready_o,
    output logic                done_o,
    output logic [DW-1:0]       rdata_o,
    output logic                mem_cs_n,
    output logic                mem_rd_n,
    output logic                mem_we_n,
    output logic [AW-1:0]       mem_addr,
    output logic [DW/8-1:0]     mem_be_n,
    output logic [DW-1:0]       mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [DW-1:0]       mem_dq_i,
    input  logic                mem_wait_n
);

    localparam int BE_W = DW / 8;

    logic [LEN_W-1:0] cs_beg, cs_end, st_beg, st_end, total, ctrl_end;
    wait_mode_e       wmode;
    logic [FLT_W-1:0] float_len;
    logic             float_opt, cur_we;
    logic [BE_W-1:0]  byte_mask;

    smc_len_decode #(.BE_W(BE_W)) u_dec (
        .setup_w  (cfg_setup),
        .pulse_w  (cfg_pulse),
        .cycle_w  (cfg_cycle),
        .mode_w   (cfg_mode),
        .is_wr    (cur_we),
        .cs_beg   (cs_beg),
        .cs_end   (cs_end),
        .st_beg   (st_beg),
        .st_end   (st_end),
        .total    (total),
        .ctrl_end (ctrl_end),
        .wmode    (wmode),
        .float_len(float_len),
        .float_opt(float_opt),
        .byte_mask(byte_mask)
    );

    smc_phase_core #(.AW(AW), .DW(DW), .BE_W(BE_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .be_i      (be_i),
        .ready_o   (ready_o),
        .done_o    (done_o),
        .rdata_o   (rdata_o),
        .cur_we_o  (cur_we),
        .cs_beg    (cs_beg),
        .cs_end    (cs_end),
        .st_beg    (st_beg),
        .st_end    (st_end),
        .total     (total),
        .ctrl_end  (ctrl_end),
        .wmode     (wmode),
        .float_len (float_len),
        .float_opt (float_opt),
        .byte_mask (byte_mask),
        .mem_cs_n  (mem_cs_n),
        .mem_rd_n  (mem_rd_n),
        .mem_we_n  (mem_we_n),
        .mem_addr  (mem_addr),
        .mem_be_n  (mem_be_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i),
        .mem_wait_n(mem_wait_n)
    );

endmodule

// File: tb/smc_timing_engine_tb_top.sv
`timescale 1ns/1ps
module smc_timing_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_setup = '0, cfg_pulse = '0, cfg_cycle = '0, cfg_mode = '0;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [3:0]  be_i = '0;
    logic        ready_o, done_o;
    logic [31:0] rdata_o;
    logic        mem_cs_n, mem_rd_n, mem_we_n, mem_dq_oe;
    logic [23:0] mem_addr;
    logic [3:0]  mem_be_n;
    logic [31:0] mem_dq_o;
    logic [31:0] mem_dq_i = '0;
    logic        mem_wait_n = 1'b1;

    int n_checks = 0;
    int n_errors = 0;
    int cyc_cnt  = 0;

    always #10 clk = ~clk;

    smc_timing_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
        .cfg_cycle(cfg_cycle), .cfg_mode(cfg_mode),
        .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i),
        .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_wait_n(mem_wait_n)
    );

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 190000) begin
            n_checks++;
            n_errors++;
            $display("FAIL R12 watchdog: actual hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int bset(input int f);
        return ((f >> 5) & 1) * 128 + (f & 31);
    endfunction
    function automatic int bpul(input int f);
        int v;
        v = ((f >> 6) & 1) * 256 + (f & 63);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic int bcyc(input int f);
        return ((f >> 7) & 3) * 256 + (f & 127);
    endfunction
    function automatic logic [31:0] fdat(input int k);
        return {8'hC3, 8'h5A, 8'(k + 7), 8'(k * 3 + 1)};
    endfunction

    task automatic run_access(input logic [31:0] su, input logic [31:0] pu, input logic [31:0] cy,
                              input logic [31:0] md, input logic we, input logic [23:0] ad,
                              input logic [31:0] wd, input logic [3:0] be,
                              input int wait_at, input int wait_len, input string tag);
        int off, stb, ste, csb, cse, tot, ce, nb, mcnt, rem, wm, guard;
        bit started, adv, fin;
        logic wn;
        logic [31:0] dmsk, exp_rd;
        logic [3:0] bmsk;
        logic [5:0] ev, av;
        off = we ? 0 : 16;
        stb = bset((su >> off) & 255);
        ste = stb + bpul((pu >> off) & 255);
        csb = bset((su >> (off + 8)) & 255);
        cse = csb + bpul((pu >> (off + 8)) & 255);
        tot = bcyc((cy >> off) & 511);
        if (ste > tot) tot = ste;
        if (cse > tot) tot = cse;
        ce  = (we ? md[1] : md[0]) ? ste : cse;
        wm  = int'(md[5:4]);
        nb  = (md[13:12] == 2'd0) ? 1 : (md[13:12] == 2'd1) ? 2 : 4;
        bmsk = 4'((1 << nb) - 1);
        for (int b = 0; b < 4; b++) dmsk[8*b +: 8] = {8{bmsk[b]}};
        cfg_setup = su; cfg_pulse = pu; cfg_cycle = cy; cfg_mode = md;
        we_i = we; addr_i = ad; wdata_i = wd; be_i = be;
        #1;
        guard = 0;
        while (!ready_o && guard < 100) begin @(negedge clk); #1; guard++; end
        req_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        we_i = ~we;
        exp_rd = rdata_o;
        mcnt = 0; started = 0; rem = 0; fin = 0;
        while (!fin) begin
            ev = {!(mcnt >= csb && mcnt < cse),
                  we ? 1'b1 : !(mcnt >= stb && mcnt < ste),
                  we ? !(mcnt >= stb && mcnt < ste) : 1'b1,
                  we, 1'b0, 1'b0};
            av = {mem_cs_n, mem_rd_n, mem_we_n, mem_dq_oe, ready_o, done_o};
            chk(av == ev, tag, 64'(av), 64'(ev));
            if (mcnt == 0) begin
                chk(mem_addr == ad, "R12", 64'(mem_addr), 64'(ad));
                chk(mem_be_n == ~(be & bmsk), "R11", 64'(mem_be_n), 64'(~(be & bmsk)));
                if (we) chk(mem_dq_o == wd, "R7", 64'(mem_dq_o), 64'(wd));
            end
            if (!started && wait_len > 0 && mcnt == wait_at) begin started = 1; rem = wait_len; end
            wn = !(started && rem > 0);
            if (started && rem > 0) rem--;
            mem_wait_n = wn;
            mem_dq_i = fdat(mcnt);
            adv = !(wm == 2 && !wn) && !(wm == 3 && !wn && mcnt == ce - 1);
            if (adv && !we && mcnt == ce - 1) exp_rd = fdat(mcnt) & dmsk;
            if (adv && mcnt == tot - 1) fin = 1;
            else if (adv) mcnt++;
            @(posedge clk);
            @(negedge clk);
        end
        mem_wait_n = 1'b1;
        av = {mem_cs_n, mem_rd_n, mem_we_n, mem_dq_oe, 1'b0, done_o};
        chk(av == 6'b111001, "R6", 64'(av), 64'(6'b111001));
        chk(rdata_o == exp_rd, we ? "R6" : (md[13:12] < 2 ? "R11" : "R5"), 64'(rdata_o), 64'(exp_rd));
    endtask

    task automatic float_probe(input logic nxt_we, input int expect_n, input string tag);
        int n;
        we_i = nxt_we;
        #1;
        n = 0;
        while (!ready_o && n < 40) begin @(negedge clk); #1; n++; end
        chk(n == expect_n, tag, 64'(n), 64'(expect_n));
    endtask

    initial begin
        int sv[3];
        int pv[3];
        int cv[3];
        logic [31:0] su, pu, cy, md;
        logic [5:0] av;
        sv = '{0, 2, 5};
        pv = '{0, 1, 3};
        cv = '{0, 4, 12};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        av = {mem_cs_n, mem_rd_n, mem_we_n, mem_dq_oe, ready_o, done_o};
        chk(av == 6'b111010, "R4", 64'(av), 64'(6'b111010));

        // sweep: setups, pulses, cycles, direction, controlling signal (R4, R3, R2, R5)
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                for (int k = 0; k < 3; k++)
                    for (int w = 0; w < 2; w++)
                        for (int c = 0; c < 2; c++) begin
                            su = {8'(sv[i] / 2 + 1), 8'(sv[i]), 8'(sv[i] / 2), 8'(sv[i] + 1)};
                            pu = {8'(pv[j] + 2), 8'(pv[j]), 8'(pv[j] + 1), 8'(pv[j])};
                            cy = {16'(cv[k] + 3), 16'(cv[k])};
                            md = 32'h0000_2000 | 32'(c) | (32'(c) << 1);
                            run_access(su, pu, cy, md, w[0], 24'(i * 9 + j * 3 + k),
                                       32'h1234_0000 + 32'(i * 100 + j * 10 + k), 4'hF, 0, 0,
                                       (cv[k] == 0) ? "R3" : (pv[j] == 0) ? "R2" : "R4");
                        end

        // compressed encodings (R1, R2, R3)
        run_access(32'h3F21_0000, 32'h0101_0000, 32'h0000_0000, 32'h2001, 1'b0, 24'h100, 0, 4'hF, 0, 0, "R1");
        run_access(32'h0000_0120, 32'h0000_0201, 32'h0000_0000, 32'h2002, 1'b1, 24'h101, 32'hDEAD_BEEF, 4'hF, 0, 0, "R1");
        run_access(32'h0000_0102, 32'h0000_407F, 32'h0000_0000, 32'h2002, 1'b1, 24'h102, 32'h0BAD_F00D, 4'hF, 0, 0, "R2");
        run_access(32'h0102_0000, 32'h0203_0000, 32'h0181_0000, 32'h2001, 1'b0, 24'h103, 0, 4'hF, 0, 0, "R3");
        run_access(32'h0000_0201, 32'h0000_0302, 32'h0000_01FF, 32'h2000, 1'b1, 24'h104, 32'h5555_AAAA, 4'hF, 0, 0, "R3");

        // frozen wait (R8)
        run_access(32'h0102_0000, 32'h0304_0000, 32'h0009_0000, 32'h2021, 1'b0, 24'h200, 0, 4'hF, 1, 4, "R8");
        run_access(32'h0000_0102, 32'h0000_0403, 32'h0000_0008, 32'h2022, 1'b1, 24'h201, 32'hCAFE_0001, 4'hF, 3, 3, "R8");
        run_access(32'h0102_0000, 32'h0304_0000, 32'h0000_0000, 32'h2020, 1'b0, 24'h202, 0, 4'hF, 0, 6, "R8");

        // ready wait on the controlling pulse end, both selections (R9)
        run_access(32'h0102_0000, 32'h0503_0000, 32'h0000_0000, 32'h2031, 1'b0, 24'h300, 0, 4'hF, 4, 5, "R9");
        run_access(32'h0102_0000, 32'h0503_0000, 32'h0000_0000, 32'h2030, 1'b0, 24'h301, 0, 4'hF, 5, 4, "R9");
        run_access(32'h0000_0102, 32'h0000_0403, 32'h0000_0000, 32'h2030, 1'b1, 24'h302, 32'h0000_1111, 4'hF, 4, 3, "R9");
        run_access(32'h0000_0102, 32'h0000_0403, 32'h0000_0000, 32'h2032, 1'b1, 24'h303, 32'h0000_2222, 4'hF, 4, 3, "R9");
        run_access(32'h0102_0000, 32'h0503_0000, 32'h0000_0000, 32'h2031, 1'b0, 24'h304, 0, 4'hF, 0, 3, "R9");
        run_access(32'h0102_0000, 32'h0503_0000, 32'h0000_0000, 32'h2001, 1'b0, 24'h305, 0, 4'hF, 3, 6, "R9");
        run_access(32'h0000_0102, 32'h0000_0403, 32'h0000_0000, 32'h2012, 1'b1, 24'h306, 32'h0000_3333, 4'hF, 2, 6, "R9");

        // data-float turnaround (R10)
        run_access(32'h0101_0000, 32'h0202_0000, 32'h0000_0000, 32'h0000_2001, 1'b0, 24'h400, 0, 4'hF, 0, 0, "R4");
        float_probe(1'b1, 1, "R10");
        run_access(32'h0101_0000, 32'h0202_0000, 32'h0000_0000, 32'h0005_2001, 1'b0, 24'h401, 0, 4'hF, 0, 0, "R4");
        float_probe(1'b1, 6, "R10");
        run_access(32'h0101_0000, 32'h0202_0000, 32'h0000_0000, 32'h000F_2001, 1'b0, 24'h402, 0, 4'hF, 0, 0, "R4");
        float_probe(1'b0, 16, "R10");
        run_access(32'h0101_0000, 32'h0202_0000, 32'h0000_0000, 32'h0017_2001, 1'b0, 24'h403, 0, 4'hF, 0, 0, "R4");
        float_probe(1'b0, 0, "R10");
        run_access(32'h0101_0000, 32'h0202_0000, 32'h0000_0000, 32'h0017_2001, 1'b0, 24'h404, 0, 4'hF, 0, 0, "R4");
        float_probe(1'b1, 8, "R10");
        run_access(32'h0000_0101, 32'h0000_0202, 32'h0000_0000, 32'h000F_2002, 1'b1, 24'h405, 32'h7777_7777, 4'hF, 0, 0, "R4");
        float_probe(1'b1, 0, "R10");

        // bus width (R11)
        run_access(32'h0101_0000, 32'h0202_0000, 32'h0000_0000, 32'h0000_0001, 1'b0, 24'h500, 0, 4'hF, 0, 0, "R11");
        run_access(32'h0101_0000, 32'h0202_0000, 32'h0000_0000, 32'h0000_1001, 1'b0, 24'h501, 0, 4'hF, 0, 0, "R11");
        run_access(32'h0000_0101, 32'h0000_0202, 32'h0000_0000, 32'h0000_1002, 1'b1, 24'h502, 32'h89AB_CDEF, 4'b1010, 0, 0, "R11");
        run_access(32'h0101_0000, 32'h0202_0000, 32'h0000_0000, 32'h0000_3001, 1'b0, 24'h503, 0, 4'b0110, 0, 0, "R11");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule